// File: doc/BRIEF.md
# Shared Operand Slot Pool

This block holds the operations that have been accepted but are still waiting on their operands. All flows draw on one pool of slots. An upstream update processor asks for a slot before it sends any operand request. It receives the slot index at once and places it in its outgoing requests. Because the slot is held before any request leaves, two flows can never each hold part of what the other needs and then wait on it.

Operand responses come back carrying the slot index and a position bit, and they fill the slot. When both operands of a slot are present, its index goes onto a ready queue, which the arithmetic unit drains one index per cycle. When the arithmetic unit takes a slot, the slot returns to the free queue.

Free and ready slots are both tracked in index FIFOs. Allocation and dispatch therefore read a queue head directly, with no search across the pool. A single-operand operation is complete after its first-position response.

Top module: `opnd_slot_pool`

## Requirements
- R1: After reset, all SLOTS indices are free and are granted in ascending order 0, 1, 2, and so on. `rdy_vld` is 0.
- R2: `alloc_gnt` equals `alloc_req` AND (a free index exists), in the same cycle. `alloc_idx` is the oldest free index, and freed indices are reused in the order they were returned.
- R3: While no index is free, `alloc_gnt` stays 0 and a held request waits. An index released in cycle t can be granted from cycle t+1, not in cycle t.
- R4: A response with `rsp_vld`=1 writes `rsp_data` into slot `rsp_idx` at the position given by `rsp_pos` (0 = first operand, 1 = second operand) and marks that position present.
- R5: The response that makes both positions of a slot present appends the slot index to the ready queue. The ready head is presented on `rdy_vld`/`rdy_idx` from the next cycle, and slots leave in the order in which they completed.
- R6: An allocation with `alloc_single`=1 marks the second position present, with the value 0. The slot is then ready after one response at position 0.
- R7: A response to a position that is already present only overwrites its value. It never queues the slot a second time.
- R8: `rdy_take` while `rdy_vld`=1 removes the ready head and appends it to the free queue. `rdy_take` while `rdy_vld`=0 is ignored. An allocation and a release in the same cycle are both performed, so no index is lost or duplicated.
- R9: `rdy_flow` and `rdy_opc` show the flow ID and opcode given at allocation, and `rdy_a` and `rdy_b` show the operand values, for the slot at the ready head.
- R10: While `rdy_vld`=1 and `rdy_take`=0, the ready head index and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Upstream asks for a slot |
| alloc_flow | input | FLOW_W | Flow ID stored in the slot |
| alloc_opc | input | OPC_W | Opcode stored in the slot |
| alloc_single | input | 1 | Operation needs only the first operand |
| alloc_gnt | output | 1 | Slot granted this cycle |
| alloc_idx | output | IW | Index of the granted slot |
| rsp_vld | input | 1 | Operand response present |
| rsp_idx | input | IW | Slot the response fills |
| rsp_pos | input | 1 | 0 = first operand, 1 = second operand |
| rsp_data | input | DATA_W | Operand value |
| rdy_vld | output | 1 | A complete slot waits at the ready head |
| rdy_idx | output | IW | Index of the ready head |
| rdy_flow | output | FLOW_W | Flow ID of the ready head |
| rdy_opc | output | OPC_W | Opcode of the ready head |
| rdy_a | output | DATA_W | First operand of the ready head |
| rdy_b | output | DATA_W | Second operand of the ready head |
| rdy_take | input | 1 | Arithmetic unit consumes the ready head |

## Verification
The bench drains the whole pool and keeps a request pending against an empty free queue. It then releases a slot in the same cycle as that request. A design that bypassed the free queue would grant in that cycle, and one that dropped the returned index would never grant again.

Responses arrive out of order, so slots complete in an order different from their allocation. The bench also sends duplicate responses to positions already present; a design that queued a slot twice would later hand the same index to two allocations.

Single-operand slots are mixed among two-operand slots. A design that did not preset the second position would leave them pending forever. A release together with an allocation on a non-empty pool shows up as a wrong free order if either index is mishandled.

// File: rtl/opnd_pool_pkg.sv
package opnd_pool_pkg;

  typedef enum logic {
    OPND_FIRST  = 1'b0,
    OPND_SECOND = 1'b1
  } opnd_pos_e;

  // True when writing position pos turns a half-filled slot into a full one.
  function automatic logic completes(input logic pos, input logic a_here, input logic b_here);
    if (pos == OPND_SECOND) return a_here && !b_here;
    else                    return b_here && !a_here;
  endfunction

endpackage

// File: rtl/idx_fifo.sv
module idx_fifo #(
  parameter int DEPTH   = 128,
  parameter int W       = 7,
  parameter bit PRELOAD = 1'b0,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_idx,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= PRELOAD ? CW'(DEPTH) : '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= PRELOAD ? W'(i) : '0;
    end else begin
      if (push) begin
        mem[wp] <= push_idx;
        wp      <= wrap_inc(wp);
      end
      if (pop) rp <= wrap_inc(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rp];
  assign count = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/slot_store.sv
module slot_store
  import opnd_pool_pkg::*;
#(
  parameter int SLOTS  = 128,
  parameter int IW     = 7,
  parameter int FLOW_W = 8,
  parameter int OPC_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IW-1:0]     alloc_idx,
  input  logic [FLOW_W-1:0] alloc_flow,
  input  logic [OPC_W-1:0]  alloc_opc,
  input  logic              alloc_single,
  input  logic              rsp_we,
  input  logic [IW-1:0]     rsp_idx,
  input  logic              rsp_pos,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [IW-1:0]     rd_idx,
  output logic [FLOW_W-1:0] rd_flow,
  output logic [OPC_W-1:0]  rd_opc,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic              became_ready
);

  logic [FLOW_W-1:0] flow_m [SLOTS];
  logic [OPC_W-1:0]  opc_m  [SLOTS];
  logic [DATA_W-1:0] a_m    [SLOTS];
  logic [DATA_W-1:0] b_m    [SLOTS];
  logic [SLOTS-1:0]  a_here, b_here;

  assign became_ready = rsp_we && completes(rsp_pos, a_here[rsp_idx], b_here[rsp_idx]);

  always_ff @(posedge clk) begin
    if (rsp_we) begin
      if (rsp_pos == OPND_SECOND) b_m[rsp_idx] <= rsp_data;
      else                        a_m[rsp_idx] <= rsp_data;
    end
    if (alloc_we) begin
      flow_m[alloc_idx] <= alloc_flow;
      opc_m[alloc_idx]  <= alloc_opc;
      if (alloc_single) b_m[alloc_idx] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_here <= '0;
      b_here <= '0;
    end else begin
      if (rsp_we) begin
        if (rsp_pos == OPND_SECOND) b_here[rsp_idx] <= 1'b1;
        else                        a_here[rsp_idx] <= 1'b1;
      end
      if (alloc_we) begin
        a_here[alloc_idx] <= 1'b0;
        b_here[alloc_idx] <= alloc_single;
      end
    end
  end

  assign rd_flow = flow_m[rd_idx];
  assign rd_opc  = opc_m[rd_idx];
  assign rd_a    = a_m[rd_idx];
  assign rd_b    = b_m[rd_idx];

  // R4
  first_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_we && rsp_pos == OPND_FIRST && !(alloc_we && alloc_idx == rsp_idx))
      |=> a_here[$past(rsp_idx)]);
  // R5
  both_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (became_ready && !(alloc_we && alloc_idx == rsp_idx))
      |=> (a_here[$past(rsp_idx)] && b_here[$past(rsp_idx)]));

endmodule

// File: rtl/opnd_slot_pool.sv
module opnd_slot_pool
  import opnd_pool_pkg::*;
#(
  parameter int SLOTS  = 128,
  parameter int FLOW_W = 8,
  parameter int OPC_W  = 4,
  parameter int DATA_W = 32,
  localparam int IW = $clog2(SLOTS),
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [FLOW_W-1:0] alloc_flow,
  input  logic [OPC_W-1:0]  alloc_opc,
  input  logic              alloc_single,
  output logic              alloc_gnt,
  output logic [IW-1:0]     alloc_idx,
  input  logic              rsp_vld,
  input  logic [IW-1:0]     rsp_idx,
  input  logic              rsp_pos,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rdy_vld,
  output logic [IW-1:0]     rdy_idx,
  output logic [FLOW_W-1:0] rdy_flow,
  output logic [OPC_W-1:0]  rdy_opc,
  output logic [DATA_W-1:0] rdy_a,
  output logic [DATA_W-1:0] rdy_b,
  input  logic              rdy_take
);

  logic [IW-1:0] free_head, rdy_head;
  logic [CW-1:0] free_cnt, rdy_cnt;
  logic          free_empty, free_full, rdy_empty, rdy_full;
  logic          release_ev, ready_ev;

  assign alloc_gnt  = alloc_req && !free_empty;
  assign alloc_idx  = free_head;
  assign rdy_vld    = !rdy_empty;
  assign rdy_idx    = rdy_head;
  assign release_ev = rdy_take && rdy_vld;

  idx_fifo #(.DEPTH(SLOTS), .W(IW), .PRELOAD(1'b1)) free_q_i (
    .clk(clk), .rst_n(rst_n),
    .push(release_ev), .push_idx(rdy_head), .pop(alloc_gnt),
    .head(free_head), .count(free_cnt), .empty(free_empty), .full(free_full)
  );

  idx_fifo #(.DEPTH(SLOTS), .W(IW), .PRELOAD(1'b0)) ready_q_i (
    .clk(clk), .rst_n(rst_n),
    .push(ready_ev), .push_idx(rsp_idx), .pop(release_ev),
    .head(rdy_head), .count(rdy_cnt), .empty(rdy_empty), .full(rdy_full)
  );

  slot_store #(
    .SLOTS(SLOTS), .IW(IW), .FLOW_W(FLOW_W), .OPC_W(OPC_W), .DATA_W(DATA_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(alloc_gnt), .alloc_idx(free_head), .alloc_flow(alloc_flow),
    .alloc_opc(alloc_opc), .alloc_single(alloc_single),
    .rsp_we(rsp_vld), .rsp_idx(rsp_idx), .rsp_pos(rsp_pos), .rsp_data(rsp_data),
    .rd_idx(rdy_head), .rd_flow(rdy_flow), .rd_opc(rdy_opc),
    .rd_a(rdy_a), .rd_b(rdy_b), .became_ready(ready_ev)
  );

  // R8
  idx_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(free_cnt) + 32'(rdy_cnt)) <= 32'(SLOTS));
  // R8
  full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_full |-> free_empty);
  // R2
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_gnt && !release_ev) |=> (free_cnt == $past(free_cnt) - 1'b1));
  // R3
  empty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_empty && alloc_req) |-> !alloc_gnt);
  // R10
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_vld && !rdy_take) |=> (rdy_vld && $stable(rdy_idx)));
  // R1
  reset_free_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (free_full && !rdy_vld));

endmodule

// File: tb/opnd_slot_pool_tb_top.sv
`timescale 1ns/1ps
module opnd_slot_pool_tb_top;
  localparam int SLOTS = 128;
  localparam int IW = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic a_req = 0, a_single = 0;
  logic [7:0] a_flow = 0;
  logic [3:0] a_opc = 0;
  logic r_vld = 0, r_pos = 0, take = 0;
  logic [IW-1:0] r_idx = 0;
  logic [31:0] r_data = 0;
  logic gnt, rv;
  logic [IW-1:0] gidx, ridx;
  logic [7:0] rflow;
  logic [3:0] ropc;
  logic [31:0] ra, rb;

  int nchk = 0, nerr = 0;
  bit done = 0;
  string phase = "R1 reset";

  int free_q[$], ready_q[$], pend_q[$];
  logic [7:0] m_flow [SLOTS];
  logic [3:0] m_opc [SLOTS];
  logic [31:0] m_a [SLOTS], m_b [SLOTS];
  bit m_ra [SLOTS], m_rb [SLOTS];

  always #10 clk = ~clk;

  opnd_slot_pool dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(a_req), .alloc_flow(a_flow), .alloc_opc(a_opc), .alloc_single(a_single),
    .alloc_gnt(gnt), .alloc_idx(gidx),
    .rsp_vld(r_vld), .rsp_idx(r_idx), .rsp_pos(r_pos), .rsp_data(r_data),
    .rdy_vld(rv), .rdy_idx(ridx), .rdy_flow(rflow), .rdy_opc(ropc),
    .rdy_a(ra), .rdy_b(rb), .rdy_take(take)
  );

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", phase, what, got, exp);
    end
  endtask

  task automatic compare();
    bit eg;
    eg = a_req && free_q.size() > 0;
    chk("alloc_gnt (R2)", 64'(gnt), 64'(eg));
    if (eg) chk("alloc_idx (R2)", 64'(gidx), 64'(free_q[0]));
    chk("rdy_vld (R5)", 64'(rv), 64'(ready_q.size() > 0));
    if (ready_q.size() > 0) begin
      chk("rdy_idx (R5)", 64'(ridx), 64'(ready_q[0]));
      chk("rdy_flow (R9)", 64'(rflow), 64'(m_flow[ready_q[0]]));
      chk("rdy_opc (R9)", 64'(ropc), 64'(m_opc[ready_q[0]]));
      chk("rdy_a (R9)", 64'(ra), 64'(m_a[ready_q[0]]));
      chk("rdy_b (R9)", 64'(rb), 64'(m_b[ready_q[0]]));
    end
  endtask

  task automatic model_update();
    bit g, rel, was;
    int s, other;
    g = a_req && free_q.size() > 0;
    rel = take && ready_q.size() > 0;
    if (r_vld) begin
      s = int'(r_idx);
      was = r_pos ? m_rb[s] : m_ra[s];
      other = r_pos ? int'(m_ra[s]) : int'(m_rb[s]);
      if (r_pos) begin m_b[s] = r_data; m_rb[s] = 1; end
      else begin m_a[s] = r_data; m_ra[s] = 1; end
      if (!was && other == 1) begin
        ready_q.push_back(s);
        foreach (pend_q[k]) if (pend_q[k] == s) begin pend_q.delete(k); break; end
      end
    end
    if (g) begin
      s = free_q.pop_front();
      m_flow[s] = a_flow; m_opc[s] = a_opc;
      m_ra[s] = 0; m_rb[s] = a_single;
      if (a_single) m_b[s] = 0;
      pend_q.push_back(s);
    end
    if (rel) free_q.push_back(ready_q.pop_front());
  endtask

  task automatic step();
    #2;
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
    a_req = 0; a_single = 0; r_vld = 0; take = 0;
  endtask

  task automatic do_alloc(input logic [7:0] f, input logic [3:0] o, input bit single);
    a_req = 1; a_flow = f; a_opc = o; a_single = single;
    step();
  endtask

  task automatic do_rsp(input int s, input bit pos, input logic [31:0] d);
    r_vld = 1; r_idx = IW'(s); r_pos = pos; r_data = d;
    step();
  endtask

  task automatic do_take();
    take = 1;
    step();
  endtask

  initial begin
    int s;
    for (int i = 0; i < SLOTS; i++) free_q.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and ascending first grants
    chk("R1 rdy_vld after reset", 64'(rv), 64'd0);
    for (int i = 0; i < 4; i++) do_alloc(8'(10 + i), 4'(i), 0);

    phase = "R4 R5 out-of-order fill";
    do_rsp(2, 1, 32'hB2); do_rsp(0, 0, 32'hA0); do_rsp(2, 0, 32'hA2);
    do_rsp(3, 0, 32'hA3); do_rsp(0, 1, 32'hB0); do_rsp(1, 1, 32'hB1);

    phase = "R7 duplicate response";
    do_rsp(3, 0, 32'hCC3); do_rsp(1, 1, 32'hDD1);
    phase = "R10 hold without take";
    step(); step();
    phase = "R8 take and reuse order";
    do_take(); do_take();
    phase = "R8 take while empty ignored";
    do_take(); do_take();
    phase = "R6 single operand";
    do_alloc(8'h55, 4'h9, 1);
    do_rsp(int'(pend_q[$]), 0, 32'h1234);
    do_rsp(1, 0, 32'hA1); do_rsp(3, 1, 32'hB3);
    phase = "R8 alloc with release";
    a_req = 1; a_flow = 8'h66; take = 1; step();
    a_req = 1; a_flow = 8'h67; take = 1; step();

    phase = "R3 exhaust pool";
    while (free_q.size() > 0) do_alloc(8'(free_q.size()), 4'(free_q.size()), free_q.size() % 3 == 0);
    a_req = 1; step();
    a_req = 1; step();
    while (ready_q.size() == 0) begin
      s = pend_q[0];
      do_rsp(s, m_ra[s] ? 1'b1 : 1'b0, 32'(s * 7));
    end
    phase = "R3 release with empty pool";
    a_req = 1; take = 1; step();
    a_req = 1; step();

    phase = "R5 R7 R8 random mix";
    for (int c = 0; c < 3000; c++) begin
      a_req = ($urandom_range(0, 2) == 0);
      a_flow = 8'($urandom); a_opc = 4'($urandom);
      a_single = ($urandom_range(0, 3) == 0);
      if (pend_q.size() > 0 && $urandom_range(0, 3) != 0) begin
        s = pend_q[$urandom_range(0, pend_q.size() - 1)];
        r_vld = 1; r_idx = IW'(s); r_data = $urandom;
        r_pos = m_ra[s] ? 1'b1 : 1'b0;
        if (m_ra[s] && $urandom_range(0, 7) == 0) r_pos = 0;
      end
      take = ($urandom_range(0, 2) != 0);
      step();
    end
    phase = "R8 final drain";
    while (pend_q.size() > 0) begin
      s = pend_q[0];
      do_rsp(s, m_ra[s] ? 1'b1 : 1'b0, 32'(s));
    end
    while (ready_q.size() > 0) do_take();
    chk("R8 all indices free", 64'(free_q.size()), 64'(SLOTS));
    for (int i = 0; i < 4; i++) do_alloc(8'h77, 4'h1, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog R1: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule